// File: doc/BRIEF.md
# Sampled Utility Monitor

This block watches the access stream of one core and estimates how many misses that core would take for every possible way allocation in a shared 16-way cache. It keeps a tag-only shadow copy of a small subset of the cache sets, replaced with true LRU and driven only by this core's addresses. Every hit in the shadow copy is credited to the recency depth at which the tag was found. Depth 0 is the most recently used entry and depth 15 the least recently used. Misses in the shadow copy are counted separately.

An allocator outside this block reads the counters. The estimated miss count for an allocation of k ways is the miss total plus the sum of the hit counters at depths k through 15. For example, with depth counts 30, 20, 15, 10 and 25 misses on a four-deep stack, one, two and three ways give 70, 50 and 35 misses. A pulse at the end of each partitioning interval halves every counter. Older history therefore fades out but is not thrown away.

Top module: `sampled_util_monitor`

## Requirements
- R1: After reset all sixteen hit counters and the miss total read zero.
- R2: The access address is split as line offset bits [5:0], set index bits [15:6] and tag bits [39:16]. The offset bits never change the lookup result, and a difference in any tag bit does.
- R3: Only sets whose index is a multiple of 33 (0, 33, ..., 1023; 32 sets) are shadowed. An access to any other set changes no counter and no shadow state.
- R4: A lookup that misses in a shadowed set adds one to the miss total. It installs the tag at depth 0 and evicts the entry at depth 15.
- R5: A lookup that hits adds one to the hit counter for the depth at which the tag was found (0 = most recent, 15 = least recent) and moves that entry to depth 0. Entries that were more recent than it each move one step deeper.
- R6: Each shadowed set holds 16 tags. After 16 distinct tags have been installed, a 17th distinct tag evicts the least recently used one, and a later lookup of the evicted tag misses.
- R7: The shadowed sets are independent: the same tag in two different sampled sets forms two separate entries.
- R8: A cycle with interval_end high replaces every counter with its value shifted right by one (rounded down). If an access is counted in the same cycle, it is added after the shift.
- R9: Counters are CNT_W bits wide (default 32). A counter at its all-ones value stays there on a further increment.
- R10: rd_hits shows the hit counter selected by rd_idx without a clock delay. An access sampled on a rising edge is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access address is present this cycle |
| acc_addr | input | 40 | Physical address of the access |
| interval_end | input | 1 | One-cycle pulse that ends a partitioning interval |
| rd_idx | input | 4 | Recency depth whose hit counter is read |
| rd_hits | output | 32 | Hit counter for depth rd_idx |
| miss_total | output | 32 | Miss count in the shadowed sets |

## Verification
Wrong recency ages inside a set show up as hits credited to the wrong depth counter. This appears on the first re-access after the corruption, one edge after the access is sampled. A broken victim choice only shows later, as an extra miss on a tag that should still be resident after 16 installs, or as a hit on a tag that should have been evicted. The tests therefore drive short, hand-computed sequences per set. They then read all sixteen counters back after each sequence, so that a single wrong credit or a missed halving is visible. Saturation is checked on a narrow instance, where the all-ones value can be reached in a few cycles.

// File: rtl/ucmon_pkg.sv
package ucmon_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_HIT  = 2'd1,
      ACC_MISS = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/ucmon_sat_ctr.sv
module ucmon_sat_ctr #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             halve,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] base;

   always_comb begin
      base = halve ? (count >> 1) : count;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (inc && (base != {CNT_W{1'b1}}))
         count <= base + 1'b1;
      else
         count <= base;
   end

   // R9: an increment never wraps to a smaller value
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !halve) |=> (count >= $past(count)));

   // R8: a halving cycle with no increment gives the floor of half
   p_halve_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (halve && !inc) |=> (count == ($past(count) >> 1)));
endmodule

// File: rtl/ucmon_shadow_set.sv
module ucmon_shadow_set #(
   parameter int WAYS  = 16,
   parameter int TAG_W = 24,
   localparam int POS_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] lookup_tag,
   input  logic             upd,
   output logic             hit,
   output logic [POS_W-1:0] hit_pos
);
   localparam logic [POS_W-1:0] OLDEST = POS_W'(WAYS - 1);

   logic             vld [WAYS];
   logic [TAG_W-1:0] tag [WAYS];
   logic [POS_W-1:0] age [WAYS];
   logic [WAYS-1:0]  match;
   logic [WAYS-1:0]  is_mru;

   always_comb begin
      hit_pos = '0;
      for (int w = 0; w < WAYS; w++) begin
         match[w]  = vld[w] && (tag[w] == lookup_tag);
         is_mru[w] = (age[w] == '0);
         hit_pos   = hit_pos | (match[w] ? age[w] : '0);
      end
      hit = |match;
   end

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld[w] <= 1'b0;
               tag[w] <= '0;
               age[w] <= POS_W'(w);
            end else if (upd) begin
               if (hit) begin
                  if (match[w])
                     age[w] <= '0;
                  else if (age[w] < hit_pos)
                     age[w] <= age[w] + 1'b1;
               end else if (age[w] == OLDEST) begin
                  vld[w] <= 1'b1;
                  tag[w] <= lookup_tag;
                  age[w] <= '0;
               end else begin
                  age[w] <= age[w] + 1'b1;
               end
            end
         end
      end
   endgenerate

   // R6: a tag is never resident in two ways of one set
   p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R5: exactly one entry occupies the most recent slot
   p_one_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(is_mru));

   // R5: after an update the looked-up tag is found at depth 0
   p_hit_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && hit) |=> (hit && hit_pos == '0) || !$stable(lookup_tag));
endmodule

// File: rtl/sampled_util_monitor.sv
module sampled_util_monitor #(
   parameter int ADDR_W = 40,
   parameter int OFF_W  = 6,
   parameter int SET_W  = 10,
   parameter int WAYS   = 16,
   parameter int STRIDE = 33,
   parameter int NSAMP  = 32,
   parameter int CNT_W  = 32,
   localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
   localparam int POS_W  = $clog2(WAYS),
   localparam int SLOT_W = $clog2(NSAMP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              interval_end,
   input  logic [POS_W-1:0]  rd_idx,
   output logic [CNT_W-1:0]  rd_hits,
   output logic [CNT_W-1:0]  miss_total
);
   import ucmon_pkg::*;

   localparam logic [SET_W-1:0] STRIDE_L = SET_W'(STRIDE);
   localparam logic [SET_W-1:0] NSAMP_L  = SET_W'(NSAMP);

   generate
      if (TAG_W < 1) begin : g_bad_split
         $error("address split leaves no tag bits");
      end
      if ((1 << POS_W) != WAYS) begin : g_bad_ways
         $error("WAYS must be a power of two");
      end
      if (STRIDE * (NSAMP - 1) >= (1 << SET_W)) begin : g_bad_sample
         $error("sampled sets exceed the set index range");
      end
   endgenerate

   logic [SET_W-1:0]  set_idx;
   logic [TAG_W-1:0]  acc_tag;
   logic [SET_W-1:0]  slot_full;
   logic [SLOT_W-1:0] slot;
   logic              sampled;
   logic [NSAMP-1:0]  hit_v;
   logic [POS_W-1:0]  pos_v [NSAMP];
   logic              sel_hit;
   logic [POS_W-1:0]  sel_pos;
   acc_kind_e         kind;
   logic [CNT_W-1:0]  hit_cnt [WAYS];

   assign set_idx   = acc_addr[OFF_W +: SET_W];
   assign acc_tag   = acc_addr[OFF_W + SET_W +: TAG_W];
   assign slot_full = set_idx / STRIDE_L;
   assign slot      = slot_full[SLOT_W-1:0];
   assign sampled   = acc_valid && ((set_idx % STRIDE_L) == '0) && (slot_full < NSAMP_L);

   generate
      for (genvar i = 0; i < NSAMP; i++) begin : g_set
         ucmon_shadow_set #(.WAYS(WAYS), .TAG_W(TAG_W)) u_set (
            .clk        (clk),
            .rst_n      (rst_n),
            .lookup_tag (acc_tag),
            .upd        (sampled && (slot == SLOT_W'(i))),
            .hit        (hit_v[i]),
            .hit_pos    (pos_v[i])
         );
      end
   endgenerate

   assign sel_hit = hit_v[slot];
   assign sel_pos = pos_v[slot];

   always_comb begin
      if (!sampled)
         kind = ACC_IDLE;
      else if (sel_hit)
         kind = ACC_HIT;
      else
         kind = ACC_MISS;
   end

   generate
      for (genvar p = 0; p < WAYS; p++) begin : g_hctr
         ucmon_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   ((kind == ACC_HIT) && (sel_pos == POS_W'(p))),
            .halve (interval_end),
            .count (hit_cnt[p])
         );
      end
   endgenerate

   ucmon_sat_ctr #(.CNT_W(CNT_W)) u_miss (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (kind == ACC_MISS),
      .halve (interval_end),
      .count (miss_total)
   );

   assign rd_hits = hit_cnt[rd_idx];

   // R3: an access outside the sampled sets leaves the miss total alone
   p_ignore_unsampled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !sampled && !interval_end) |=> $stable(miss_total));

   // R4: a shadow miss below saturation raises the miss total by one
   p_miss_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sampled && !sel_hit && !interval_end && (miss_total != {CNT_W{1'b1}}))
      |=> (miss_total == $past(miss_total) + 1'b1));

   // R5: a hit never changes the miss total
   p_hit_no_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sampled && sel_hit && !interval_end) |=> $stable(miss_total));
endmodule

// File: tb/sampled_util_monitor_test.sv
module sampled_util_monitor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [39:0] acc_addr = '0;
   logic        interval_end = 1'b0;
   logic [3:0]  rd_idx = '0;
   logic [31:0] rd_hits, miss_total;

   logic        n_valid = 1'b0;
   logic [39:0] n_addr = '0;
   logic        n_end = 1'b0;
   logic [3:0]  n_hits, n_miss;

   int vectors = 0;
   int fails = 0;
   int exp_hit [16];
   int exp_miss = 0;

   always #5 clk = ~clk;

   sampled_util_monitor uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .interval_end(interval_end), .rd_idx(rd_idx), .rd_hits(rd_hits),
      .miss_total(miss_total));

   sampled_util_monitor #(.CNT_W(4)) uut_narrow (
      .clk(clk), .rst_n(rst_n), .acc_valid(n_valid), .acc_addr(n_addr),
      .interval_end(n_end), .rd_idx(4'd0), .rd_hits(n_hits),
      .miss_total(n_miss));

   function automatic logic [39:0] mk(input int set, input logic [23:0] tag,
                                      input logic [5:0] off);
      return {tag, 10'(set), off};
   endfunction

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int p = 0; p < 16; p++) begin
         rd_idx = 4'(p);
         #1;
         check(req, $sformatf("hit depth %0d", p), rd_hits, exp_hit[p]);
      end
      check(req, "miss total", miss_total, exp_miss);
   endtask

   task automatic acc(input int set, input logic [23:0] tag,
                      input logic [5:0] off, input logic iend);
      @(negedge clk);
      acc_valid    = 1'b1;
      acc_addr     = mk(set, tag, off);
      interval_end = iend;
      @(negedge clk);
      acc_valid    = 1'b0;
      interval_end = 1'b0;
   endtask

   task automatic halve_exp();
      for (int p = 0; p < 16; p++) exp_hit[p] = exp_hit[p] >> 1;
      exp_miss = exp_miss >> 1;
   endtask

   // R1
   task automatic t_reset();
      for (int p = 0; p < 16; p++) exp_hit[p] = 0;
      exp_miss = 0;
      check_all("R1");
   endtask

   // R2 R3 R4 R5 R7
   task automatic t_miss_hit();
      acc(0, 24'h00000A, 6'd0, 1'b0);
      exp_miss = 1;
      check("R4", "first miss", miss_total, exp_miss);
      acc(1, 24'h00000A, 6'd0, 1'b0);
      acc(32, 24'h00000B, 6'd0, 1'b0);
      acc(34, 24'h00000C, 6'd0, 1'b0);
      check_all("R3");
      acc(33, 24'h00000A, 6'd0, 1'b0);
      exp_miss = 2;
      check("R7", "same tag other set", miss_total, exp_miss);
      acc(0, 24'h00000A, 6'd0, 1'b0);
      exp_hit[0] = 1;
      check_all("R5");
      acc(0, 24'h00000A, 6'h3F, 1'b0);
      exp_hit[0] = 2;
      check_all("R2");
      acc(0, 24'h80000A, 6'd0, 1'b0);
      exp_miss = 3;
      check_all("R2");
   endtask

   // R5 R10
   task automatic t_recency();
      for (int t = 1; t <= 4; t++) acc(66, 24'(t), 6'd0, 1'b0);
      exp_miss += 4;
      acc(66, 24'd1, 6'd0, 1'b0);
      exp_hit[3] = 1;
      acc(66, 24'd1, 6'd0, 1'b0);
      exp_hit[0] = 3;
      acc(66, 24'd2, 6'd0, 1'b0);
      exp_hit[3] = 2;
      check_all("R5");
      rd_idx = 4'd3;
      #1;
      check("R10", "read depth 3", rd_hits, 2);
      rd_idx = 4'd0;
      #1;
      check("R10", "read depth 0", rd_hits, 3);
   endtask

   // R6
   task automatic t_evict();
      for (int t = 100; t < 116; t++) acc(1023, 24'(t), 6'd0, 1'b0);
      exp_miss += 16;
      acc(1023, 24'd100, 6'd0, 1'b0);
      exp_hit[15] = 1;
      check("R6", "oldest depth", exp_hit[15], 1);
      acc(1023, 24'd116, 6'd0, 1'b0);
      acc(1023, 24'd101, 6'd0, 1'b0);
      exp_miss += 2;
      acc(1023, 24'd100, 6'd0, 1'b0);
      exp_hit[2] = 1;
      check_all("R6");
   endtask

   // R8
   task automatic t_halve();
      @(negedge clk);
      interval_end = 1'b1;
      @(negedge clk);
      interval_end = 1'b0;
      halve_exp();
      check_all("R8");
      acc(0, 24'h80000A, 6'd0, 1'b1);
      halve_exp();
      exp_hit[0] += 1;
      check_all("R8");
   endtask

   // R9
   task automatic t_saturate();
      for (int t = 0; t < 20; t++) begin
         @(negedge clk);
         n_valid = 1'b1;
         n_addr  = mk(0, 24'(t + 500), 6'd0);
      end
      @(negedge clk);
      n_valid = 1'b0;
      check("R9", "narrow miss saturates", n_miss, 15);
      n_end = 1'b1;
      @(negedge clk);
      n_end = 1'b0;
      check("R9", "narrow halve after saturation", n_miss, 7);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_miss_hit();
      t_recency();
      t_evict();
      t_halve();
      t_saturate();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule